// File: doc/BRIEF.md
# Multi-Way Tag ECC Error Logger

This block sits beside the tag array of an eight-way set-associative cache. On every tag probe it takes the probe index, the stored tag word and check bits of every way, and the hit information. It decodes all eight ways in parallel with a single-error-correct, double-error-detect code. The corrected tags are returned in the same cycle, ready for hit comparison. A per-way mask reports which ways hold an uncorrectable tag.

Errors are also recorded in one control/status word. Sticky single-error and double-error flags are kept there, together with a capture of the failing index, the failing way and the syndrome. The syndrome is recorded only when the logged way is the hit way. Two interrupt outputs follow the flags through separate enables. Software reads the word continuously on `csr_rdata`. A write updates the control bits and clears a flag where a one is written. Reset is taken asynchronously and released through a two-stage synchronizer.

Top module: `tag_ecc_logger`

## Requirements
- R1: Tag word bit 18 is valid, bit 17 is dirty, bit 16 is lock and bits 15:0 are the address tag. Data bit i sits at codeword position p(i), where p runs 3,5,6,7,9..15,17..24 for i = 0..18. Check bit k (k = 0..4) is the XOR of the data bits whose p(i) has bit k set. Check bit 5 is the XOR of all data bits and check bits 0..4. With checking on, a way with one flipped data bit shows the original word on `tag_out` in the same cycle, and an error-free way shows its stored word.
- R2: With checking on, `way_dbe` bit w is 1 in the same cycle when way w has two flipped bits, and it is 0 for ways with zero or one flipped bit.
- R3: Status bit 0 (single flag) is set at the clock edge of a valid probe in which any way has a single-bit error. Status bit 1 (double flag) is set likewise for a double-bit error. Both flags stay set until cleared. A probe with `probe_valid` low changes nothing.
- R4: A capture records the 11-bit probe index in bits 24:14, so index 2047 is representable. It records the logged way in bits 7:5 and a 6-bit syndrome in bits 13:8. The syndrome is {overall parity mismatch, recomputed check XOR stored check bits 4..0}. It is recorded only when `probe_hit` is set and the logged way equals `probe_hit_way`; otherwise the recorded syndrome is zero.
- R5: If a probe has any double-bit error, only ways with double-bit errors are candidates for logging; otherwise ways with single-bit errors are. Among the candidates, the hit way is logged if it is one of them, else the lowest-numbered candidate.
- R6: A double-bit error replaces a held single-error capture. A double-bit error arriving while the double flag is held leaves the capture unchanged.
- R7: A single-bit error arriving while either flag is held leaves the capture unchanged.
- R8: A write to the status word loads bit 2 (check enable), bit 3 (single interrupt enable) and bit 4 (double interrupt enable). Writing 1 to bit 0 or bit 1 clears that flag; writing 0 leaves it. Once both flags are clear, the next error is captured. An error in the same cycle as its clear leaves the flag set and takes the capture.
- R9: `irq_sbe` is high exactly when the single flag and bit 3 are both set. `irq_dbe` is high exactly when the double flag and bit 4 are both set.
- R10: With bit 2 clear, `tag_out` equals the raw stored tags, `way_dbe` is zero, and probes set no flag and change no capture.
- R11: After reset the status word reads zero and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_valid | input | 1 | A tag probe is presented this cycle |
| probe_index | input | 11 | Cache line index of the probe |
| probe_hit | input | 1 | The probe hit in some way |
| probe_hit_way | input | 3 | Way number of the hit |
| probe_tags | input | 152 | Stored tag words, way w at bits w*19 +: 19 |
| probe_checks | input | 48 | Stored check bits, way w at bits w*6 +: 6 |
| tag_out | output | 152 | Corrected tag words, same packing as probe_tags |
| way_dbe | output | 8 | Per-way uncorrectable error mask |
| csr_wr | input | 1 | Write strobe for the status word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Status word |
| irq_sbe | output | 1 | Single-error interrupt |
| irq_dbe | output | 1 | Double-error interrupt |

## Verification
The bench goes after probes that carry errors in several ways at once: hit and non-hit ways, a single error beside a double error, and two double errors. A selector with the wrong priority would log the wrong way, or would keep a syndrome that must read zero. It walks the capture policy through single-after-single, double-after-single and single-after-double. A capture that is not held or not overwritten shows up as a wrong index in the status word. It also checks a clear and an error landing in the same cycle, partial clears, a probe with valid low, disabled checking, and interrupt enables toggled after a flag is already set. A design that dropped the flag, captured while disabled, or left the interrupt ungated would show the wrong status word or interrupt level at the next sample.

// File: rtl/tag_ecc_pkg.sv
package tag_ecc_pkg;

  // Status word bit positions that software decodes.
  localparam int FLD_SBE = 0;
  localparam int FLD_DBE = 1;
  localparam int FLD_EN  = 2;
  localparam int FLD_SIE = 3;
  localparam int FLD_DIE = 4;

  // Codeword position of data bit i: the i-th integer >= 3 that is not a
  // power of two.
  function automatic int unsigned ham_pos(input int unsigned i);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    for (int unsigned p = 3; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == i && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/tag_secded_dec.sv
module tag_secded_dec #(
  parameter int TAG_W = 19,
  parameter int CHK_W = 6
) (
  input  logic             ecc_on,
  input  logic [TAG_W-1:0] tag_in,
  input  logic [CHK_W-1:0] chk_in,
  output logic [TAG_W-1:0] tag_out,
  output logic [CHK_W-1:0] syn,
  output logic             err_single,
  output logic             err_double
);
  import tag_ecc_pkg::*;

  localparam int HAM_W = CHK_W - 1;

  logic [HAM_W-1:0] syn_h;
  logic             par;
  logic [TAG_W-1:0] flip;
  logic             chk_pos;
  logic             single_raw;

  always_comb begin
    syn_h = chk_in[HAM_W-1:0];
    for (int i = 0; i < TAG_W; i++) begin
      for (int k = 0; k < HAM_W; k++) begin
        if (((ham_pos(i) >> k) & 1) == 1) syn_h[k] = syn_h[k] ^ tag_in[i];
      end
    end
    par = ^{tag_in, chk_in};
    for (int i = 0; i < TAG_W; i++) begin
      flip[i] = par && (syn_h == HAM_W'(ham_pos(i)));
    end
    // Syndrome naming one of the check bits themselves.
    chk_pos    = (syn_h != '0) && ((syn_h & (syn_h - 1'b1)) == '0);
    single_raw = par && ((syn_h == '0) || chk_pos || (|flip));
  end

  assign tag_out    = ecc_on ? (tag_in ^ flip) : tag_in;
  assign syn        = ecc_on ? {par, syn_h} : '0;
  assign err_single = ecc_on && single_raw;
  assign err_double = ecc_on && ({par, syn_h} != '0) && !single_raw;

endmodule

// File: rtl/tag_err_pick.sv
module tag_err_pick #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  sbe_mask,
  input  logic [WAYS-1:0]  dbe_mask,
  input  logic             hit,
  input  logic [WAY_W-1:0] hit_way,
  output logic             any_err,
  output logic [WAY_W-1:0] sel_way,
  output logic             sel_is_hit
);

  logic [WAYS-1:0]  cand;
  logic [WAY_W-1:0] lowest;

  always_comb begin
    // Uncorrectable errors outrank correctable ones.
    cand    = (|dbe_mask) ? dbe_mask : sbe_mask;
    any_err = |cand;
    lowest  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (cand[w]) lowest = WAY_W'(w);
    end
    if (hit && cand[hit_way]) begin
      sel_way    = hit_way;
      sel_is_hit = 1'b1;
    end else begin
      sel_way    = lowest;
      sel_is_hit = 1'b0;
    end
  end

endmodule

// File: rtl/tag_err_log.sv
module tag_err_log #(
  parameter int IDX_W = 11,
  parameter int WAY_W = 3,
  parameter int CHK_W = 6,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             probe_valid,
  input  logic [IDX_W-1:0] probe_index,
  input  logic             any_sbe,
  input  logic             any_dbe,
  input  logic [WAY_W-1:0] sel_way,
  input  logic             sel_is_hit,
  input  logic [CHK_W-1:0] sel_syn,
  input  logic             csr_wr,
  input  logic [REG_W-1:0] csr_wdata,
  output logic [REG_W-1:0] csr_rdata,
  output logic             ecc_on,
  output logic             irq_sbe,
  output logic             irq_dbe
);
  import tag_ecc_pkg::*;

  localparam int F_WAY = FLD_DIE + 1;
  localparam int F_SYN = F_WAY + WAY_W;
  localparam int F_IDX = F_SYN + CHK_W;
  localparam int CAP_W = IDX_W + WAY_W + CHK_W;

  logic             sbe_q, dbe_q, en_q, sie_q, die_q;
  logic             sbe_d, dbe_d, en_d, sie_d, die_d;
  logic [CAP_W-1:0] cap_q, cap_d;
  logic             cap_en;
  logic             clr_s, clr_d, held_s, held_d, ev_s, ev_d;
  logic             unused_wdata;

  assign unused_wdata = ^csr_wdata[REG_W-1:FLD_DIE+1];

  // Next-state logic
  always_comb begin
    clr_s  = csr_wr && csr_wdata[FLD_SBE];
    clr_d  = csr_wr && csr_wdata[FLD_DBE];
    held_s = sbe_q && !clr_s;
    held_d = dbe_q && !clr_d;
    ev_s   = probe_valid && en_q && any_sbe;
    ev_d   = probe_valid && en_q && any_dbe;
    sbe_d  = held_s || ev_s;
    dbe_d  = held_d || ev_d;
    en_d   = csr_wr ? csr_wdata[FLD_EN]  : en_q;
    sie_d  = csr_wr ? csr_wdata[FLD_SIE] : sie_q;
    die_d  = csr_wr ? csr_wdata[FLD_DIE] : die_q;
    if (ev_d) cap_en = !held_d;
    else      cap_en = ev_s && !held_s && !held_d;
    cap_d  = {probe_index, sel_way, (sel_is_hit ? sel_syn : {CHK_W{1'b0}})};
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbe_q <= 1'b0;
      dbe_q <= 1'b0;
      en_q  <= 1'b0;
      sie_q <= 1'b0;
      die_q <= 1'b0;
      cap_q <= '0;
    end else begin
      sbe_q <= sbe_d;
      dbe_q <= dbe_d;
      if (csr_wr) begin
        en_q  <= en_d;
        sie_q <= sie_d;
        die_q <= die_d;
      end
      if (cap_en) cap_q <= cap_d;
    end
  end

  always_comb begin
    csr_rdata                  = '0;
    csr_rdata[FLD_SBE]         = sbe_q;
    csr_rdata[FLD_DBE]         = dbe_q;
    csr_rdata[FLD_EN]          = en_q;
    csr_rdata[FLD_SIE]         = sie_q;
    csr_rdata[FLD_DIE]         = die_q;
    csr_rdata[F_SYN +: CHK_W]  = cap_q[CHK_W-1:0];
    csr_rdata[F_WAY +: WAY_W]  = cap_q[CHK_W +: WAY_W];
    csr_rdata[F_IDX +: IDX_W]  = cap_q[CHK_W+WAY_W +: IDX_W];
  end

  assign ecc_on  = en_q;
  assign irq_sbe = sbe_q && sie_q;
  assign irq_dbe = dbe_q && die_q;

  // R3: a flag stays set until software clears it
  a_r3_sbe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_q && !clr_s) |=> sbe_q);

  // R6: a held double-error capture is never replaced
  a_r6_dbe_keeps_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (dbe_q && !clr_d) |=> $stable(cap_q));

  // R7: a single error cannot disturb a held capture
  a_r7_sbe_keeps_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_q && !clr_s && !ev_d) |=> $stable(cap_q));

  // R10: disabled checking leaves flags and capture alone
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!$rose(sbe_q) && !$rose(dbe_q) && $stable(cap_q)));

  // R9: an interrupt only rises after an error event or a control write
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sbe) |-> ($past(ev_s) || $past(csr_wr)));

endmodule

// File: rtl/tag_ecc_logger.sv
module tag_ecc_logger #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 19,
  parameter int CHK_W = 6,
  parameter int IDX_W = 11,
  parameter int REG_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    probe_valid,
  input  logic [IDX_W-1:0]        probe_index,
  input  logic                    probe_hit,
  input  logic [$clog2(WAYS)-1:0] probe_hit_way,
  input  logic [WAYS*TAG_W-1:0]   probe_tags,
  input  logic [WAYS*CHK_W-1:0]   probe_checks,
  output logic [WAYS*TAG_W-1:0]   tag_out,
  output logic [WAYS-1:0]         way_dbe,
  input  logic                    csr_wr,
  input  logic [REG_W-1:0]        csr_wdata,
  output logic [REG_W-1:0]        csr_rdata,
  output logic                    irq_sbe,
  output logic                    irq_dbe
);

  localparam int WAY_W = $clog2(WAYS);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  logic             ecc_on;
  logic [WAYS-1:0]  sbe_mask;
  logic [WAYS-1:0]  dbe_mask;
  logic [CHK_W-1:0] way_syn [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tag_secded_dec #(
      .TAG_W (TAG_W),
      .CHK_W (CHK_W)
    ) u_dec (
      .ecc_on     (ecc_on),
      .tag_in     (probe_tags[w*TAG_W +: TAG_W]),
      .chk_in     (probe_checks[w*CHK_W +: CHK_W]),
      .tag_out    (tag_out[w*TAG_W +: TAG_W]),
      .syn        (way_syn[w]),
      .err_single (sbe_mask[w]),
      .err_double (dbe_mask[w])
    );
  end

  assign way_dbe = dbe_mask;

  logic             any_err;
  logic [WAY_W-1:0] sel_way;
  logic             sel_is_hit;

  tag_err_pick #(
    .WAYS (WAYS)
  ) u_pick (
    .sbe_mask   (sbe_mask),
    .dbe_mask   (dbe_mask),
    .hit        (probe_hit),
    .hit_way    (probe_hit_way),
    .any_err    (any_err),
    .sel_way    (sel_way),
    .sel_is_hit (sel_is_hit)
  );

  // R5: the chosen way really carries an error of the winning class
  a_r5_pick_has_error: assert property (@(posedge clk) disable iff (!rst_sync)
    any_err |-> ((|dbe_mask) ? dbe_mask[sel_way] : sbe_mask[sel_way]));

  tag_err_log #(
    .IDX_W (IDX_W),
    .WAY_W (WAY_W),
    .CHK_W (CHK_W),
    .REG_W (REG_W)
  ) u_log (
    .clk         (clk),
    .rst_n       (rst_sync),
    .probe_valid (probe_valid),
    .probe_index (probe_index),
    .any_sbe     (|sbe_mask),
    .any_dbe     (|dbe_mask),
    .sel_way     (sel_way),
    .sel_is_hit  (sel_is_hit),
    .sel_syn     (way_syn[sel_way]),
    .csr_wr      (csr_wr),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .ecc_on      (ecc_on),
    .irq_sbe     (irq_sbe),
    .irq_dbe     (irq_dbe)
  );

endmodule

// File: tb/tag_ecc_logger_bench.sv
module tag_ecc_logger_bench;

  localparam int WAYS  = 8;
  localparam int TAG_W = 19;
  localparam int CHK_W = 6;
  localparam int IDX_W = 11;
  localparam int REG_W = 32;
  localparam logic [4:0] N = 5'd31;

  typedef struct packed {
    logic       hit;
    logic [2:0] hway;
    logic [2:0] wa;
    logic [4:0] a0;
    logic [4:0] a1;
    logic [2:0] wb;
    logic [4:0] b0;
    logic [4:0] b1;
    logic [2:0] xway;
    logic       xs;
    logic       xd;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1, 3'd2, 3'd0, N,     N,     3'd0, N,     N,     3'd0, 1'b0, 1'b0},
    '{1'b1, 3'd3, 3'd3, 5'd5,  N,     3'd0, N,     N,     3'd3, 1'b1, 1'b0},
    '{1'b1, 3'd1, 3'd6, 5'd0,  N,     3'd0, N,     N,     3'd6, 1'b1, 1'b0},
    '{1'b1, 3'd0, 3'd0, 5'd2,  5'd9,  3'd0, N,     N,     3'd0, 1'b0, 1'b1},
    '{1'b1, 3'd5, 3'd1, 5'd18, N,     3'd5, 5'd11, N,     3'd5, 1'b1, 1'b0},
    '{1'b0, 3'd4, 3'd4, 5'd7,  N,     3'd2, 5'd16, N,     3'd2, 1'b1, 1'b0},
    '{1'b1, 3'd1, 3'd1, 5'd3,  N,     3'd7, 5'd1,  5'd17, 3'd7, 1'b1, 1'b1},
    '{1'b1, 3'd6, 3'd4, 5'd4,  5'd5,  3'd6, 5'd10, 5'd12, 3'd6, 1'b0, 1'b1}
  };

  logic                  clk;
  logic                  rst_n;
  logic                  probe_valid;
  logic [IDX_W-1:0]      probe_index;
  logic                  probe_hit;
  logic [2:0]            probe_hit_way;
  logic [WAYS*TAG_W-1:0] probe_tags;
  logic [WAYS*CHK_W-1:0] probe_checks;
  logic [WAYS*TAG_W-1:0] tag_out;
  logic [WAYS-1:0]       way_dbe;
  logic                  csr_wr;
  logic [REG_W-1:0]      csr_wdata;
  logic [REG_W-1:0]      csr_rdata;
  logic                  irq_sbe;
  logic                  irq_dbe;

  tag_ecc_logger u_tag_ecc_logger (
    .clk           (clk),
    .rst_n         (rst_n),
    .probe_valid   (probe_valid),
    .probe_index   (probe_index),
    .probe_hit     (probe_hit),
    .probe_hit_way (probe_hit_way),
    .probe_tags    (probe_tags),
    .probe_checks  (probe_checks),
    .tag_out       (tag_out),
    .way_dbe       (way_dbe),
    .csr_wr        (csr_wr),
    .csr_wdata     (csr_wdata),
    .csr_rdata     (csr_rdata),
    .irq_sbe       (irq_sbe),
    .irq_dbe       (irq_dbe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [TAG_W-1:0] base [WAYS];
  logic [TAG_W-1:0] flip [WAYS];

  function automatic int bpos(input int i);
    int n;
    n = 0;
    for (int p = 1; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == i) return p;
        n++;
      end
    end
    return 0;
  endfunction

  function automatic logic [5:0] enc(input logic [TAG_W-1:0] d);
    logic [5:0] c;
    c = '0;
    for (int i = 0; i < TAG_W; i++)
      for (int k = 0; k < 5; k++)
        if (((bpos(i) >> k) & 1) == 1) c[k] = c[k] ^ d[i];
    c[5] = ^d ^ ^c[4:0];
    return c;
  endfunction

  function automatic logic [5:0] exp_syn(input logic [TAG_W-1:0] m);
    logic [4:0] h;
    h = '0;
    for (int i = 0; i < TAG_W; i++)
      if (m[i]) h = h ^ 5'(bpos(i));
    return {^m, h};
  endfunction

  function automatic logic [31:0] word(input logic s, input logic d, input logic en,
                                       input logic sie, input logic die, input logic [2:0] w,
                                       input logic [5:0] sy, input logic [10:0] idx);
    return {7'd0, idx, sy, w, die, sie, en, d, s};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_flips();
    for (int w = 0; w < WAYS; w++) flip[w] = '0;
  endtask

  task automatic set_err(input int w, input int b0, input int b1);
    if (b0 < TAG_W) flip[w][b0] = 1'b1;
    if (b1 < TAG_W) flip[w][b1] = 1'b1;
  endtask

  task automatic apply(input logic [10:0] idx, input logic hit, input logic [2:0] hw);
    for (int w = 0; w < WAYS; w++) begin
      probe_tags[w*TAG_W +: TAG_W]   = base[w] ^ flip[w];
      probe_checks[w*CHK_W +: CHK_W] = enc(base[w]);
    end
    probe_index   = idx;
    probe_hit     = hit;
    probe_hit_way = hw;
    probe_valid   = 1'b1;
  endtask

  task automatic probe_cycle(input logic [10:0] idx, input logic hit, input logic [2:0] hw);
    @(negedge clk);
    apply(idx, hit, hw);
    @(negedge clk);
    probe_valid = 1'b0;
  endtask

  task automatic csr_write(input logic [31:0] v);
    @(negedge clk);
    csr_wr    = 1'b1;
    csr_wdata = v;
    @(negedge clk);
    csr_wr    = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0]  e_way;
    logic [5:0]  e_syn;
    logic [10:0] e_idx;
    logic [5:0]  s_keep;
    logic [10:0] idx;
    logic [7:0]  xmask;

    rst_n = 1'b0; probe_valid = 1'b0; probe_index = '0; probe_hit = 1'b0;
    probe_hit_way = '0; probe_tags = '0; probe_checks = '0;
    csr_wr = 1'b0; csr_wdata = '0;
    for (int w = 0; w < WAYS; w++)
      base[w] = {1'b1, w[0], w[1], 16'(16'h3C5A ^ (w * 16'h0F11))};
    clear_flips();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    check("R11 status after reset", csr_rdata, 32'h0);
    check("R11 irqs after reset", {30'd0, irq_sbe, irq_dbe}, 32'h0);

    // R10: checking disabled
    clear_flips();
    set_err(0, 4, 31);
    set_err(1, 2, 3);
    @(negedge clk);
    apply(11'd5, 1'b1, 3'd0);
    #1;
    check("R10 raw passthrough", 32'(tag_out[0 +: TAG_W]), 32'(base[0] ^ flip[0]));
    check("R10 no dbe mask", 32'(way_dbe), 32'h0);
    @(negedge clk);
    probe_valid = 1'b0;
    check("R10 no flag no capture", csr_rdata, 32'h0);

    // Table walk: R1 R2 R3 R4 R5 R9
    e_way = '0; e_syn = '0; e_idx = '0;
    for (int r = 0; r < NROWS; r++) begin
      csr_write(32'h1F);
      clear_flips();
      set_err(int'(ROWS[r].wa), int'(ROWS[r].a0), int'(ROWS[r].a1));
      set_err(int'(ROWS[r].wb), int'(ROWS[r].b0), int'(ROWS[r].b1));
      idx = 11'(r * 211 + 7);
      @(negedge clk);
      apply(idx, ROWS[r].hit, ROWS[r].hway);
      #1;
      xmask = '0;
      for (int w = 0; w < WAYS; w++) begin
        if ($countones(flip[w]) == 2) xmask[w] = 1'b1;
        else check($sformatf("R1 row %0d way %0d corrected", r, w),
                   32'(tag_out[w*TAG_W +: TAG_W]), 32'(base[w]));
      end
      check($sformatf("R2 row %0d dbe mask", r), 32'(way_dbe), 32'(xmask));
      @(negedge clk);
      probe_valid = 1'b0;
      if (ROWS[r].xs || ROWS[r].xd) begin
        e_way = ROWS[r].xway;
        e_idx = idx;
        e_syn = (ROWS[r].hit && ROWS[r].hway == ROWS[r].xway) ? exp_syn(flip[ROWS[r].xway]) : 6'd0;
      end
      check($sformatf("R3 R4 R5 row %0d status", r), csr_rdata,
            word(ROWS[r].xs, ROWS[r].xd, 1'b1, 1'b1, 1'b1, e_way, e_syn, e_idx));
      check($sformatf("R9 row %0d irqs", r), {30'd0, irq_sbe, irq_dbe},
            {30'd0, ROWS[r].xs, ROWS[r].xd});
    end

    // R7: single after single keeps the first capture
    csr_write(32'h1F);
    clear_flips(); set_err(2, 8, 31);
    s_keep = exp_syn(flip[2]);
    probe_cycle(11'd100, 1'b1, 3'd2);
    check("R4 first single capture", csr_rdata, word(1, 0, 1, 1, 1, 3'd2, s_keep, 11'd100));
    clear_flips(); set_err(5, 3, 31);
    probe_cycle(11'd200, 1'b1, 3'd5);
    check("R7 second single ignored", csr_rdata, word(1, 0, 1, 1, 1, 3'd2, s_keep, 11'd100));

    // R6: double overwrites single, then later errors are ignored
    clear_flips(); set_err(3, 1, 14);
    probe_cycle(11'd300, 1'b1, 3'd0);
    check("R6 double overwrites single", csr_rdata, word(1, 1, 1, 1, 1, 3'd3, 6'd0, 11'd300));
    clear_flips(); set_err(1, 0, 6);
    probe_cycle(11'd400, 1'b1, 3'd1);
    check("R6 second double ignored", csr_rdata, word(1, 1, 1, 1, 1, 3'd3, 6'd0, 11'd300));
    clear_flips(); set_err(4, 2, 31);
    probe_cycle(11'd500, 1'b1, 3'd4);
    check("R7 single after double ignored", csr_rdata, word(1, 1, 1, 1, 1, 3'd3, 6'd0, 11'd300));

    // R8: write-one-to-clear behaviour
    csr_write(32'h1D);
    check("R8 clear single only", csr_rdata, word(0, 1, 1, 1, 1, 3'd3, 6'd0, 11'd300));
    clear_flips(); set_err(6, 11, 31);
    probe_cycle(11'd600, 1'b1, 3'd6);
    check("R8 double still blocks capture", csr_rdata, word(1, 1, 1, 1, 1, 3'd3, 6'd0, 11'd300));
    csr_write(32'h1F);
    check("R8 both cleared", csr_rdata, word(0, 0, 1, 1, 1, 3'd3, 6'd0, 11'd300));
    clear_flips(); set_err(0, 18, 31);
    s_keep = exp_syn(flip[0]);
    probe_cycle(11'd2047, 1'b1, 3'd0);
    check("R8 R4 new capture at top index", csr_rdata, word(1, 0, 1, 1, 1, 3'd0, s_keep, 11'd2047));

    // R8: error in the same cycle as its clear
    clear_flips(); set_err(7, 9, 31);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = 32'h1F;
    apply(11'd33, 1'b0, 3'd0);
    @(negedge clk);
    csr_wr = 1'b0; probe_valid = 1'b0;
    check("R8 same-cycle event wins", csr_rdata, word(1, 0, 1, 1, 1, 3'd7, 6'd0, 11'd33));

    // R9: enables gate the interrupts
    csr_write(32'h07);
    clear_flips(); set_err(5, 1, 31);
    probe_cycle(11'd77, 1'b0, 3'd0);
    check("R9 flag set with enables off", csr_rdata, word(1, 0, 1, 0, 0, 3'd5, 6'd0, 11'd77));
    check("R9 irq masked", {30'd0, irq_sbe, irq_dbe}, 32'h0);
    csr_write(32'h1C);
    check("R9 irq after enable", {30'd0, irq_sbe, irq_dbe}, 32'h2);

    // R3: probe without valid changes nothing
    csr_write(32'h1F);
    clear_flips(); set_err(2, 6, 31);
    @(negedge clk);
    apply(11'd900, 1'b1, 3'd2);
    probe_valid = 1'b0;
    @(negedge clk);
    check("R3 invalid probe ignored", csr_rdata, word(0, 0, 1, 1, 1, 3'd5, 6'd0, 11'd77));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule